// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple synchronous request port and an external asynchronous static RAM with 64K words of 16 bits. A client presents an address, write data, a two-bit lane mask and a read/write flag with a valid strobe. The controller then runs one access on the memory pins and finishes it with a one-cycle done pulse. For reads, the done pulse comes with the returned word. The memory pins are the active-low chip select, output enable, write enable and two active-low lane enables, plus a 16-bit data bus. The bus is split into an output value, an output-enable and an input value, so the pad tri-state sits outside the block.

Every timing interval is counted in system clock cycles:

- the read access window, `T_RD`;
- the write pulse, `T_WP`;
- the bus turnaround, `T_TURN`.

By default these are derived from the nanosecond minimums of a 15 ns part, rounded up at the clock period `CLK_PS`.

Writes are framed by the write-enable strobe. Output enable stays inactive for the whole write, so the minimum pulse width is enough. The controller never drives the data bus until output enable has been inactive for the turnaround interval. When idle, the memory is deselected into standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, chip select, output enable, write enable and both lane enables are high (inactive), `mem_dq_oe` is 0 and `rsp_done` is 0.
- R2: A read holds output enable low for exactly `T_RD` consecutive cycles, with chip select low, write enable high and `mem_addr` equal to the request address.
- R3: Lane mask bit 0 selects the low lane (data bits 7:0, enable `mem_lb_n`) and bit 1 selects the high lane (bits 15:8, enable `mem_ub_n`). During an access, a lane enable is low only if its mask bit is 1. Read data is captured on the last cycle of the access window, and unselected lanes return as zero.
- R4: A write holds write enable low for exactly `T_WP` consecutive cycles with output enable high throughout, and only the selected lanes of the addressed word change.
- R5: `mem_dq_oe` rises exactly `T_TURN` cycles after a write is accepted. It stays high only while write enable is low and for one data-hold cycle after, so it is high for `T_WP`+1 cycles per write.
- R6: `mem_dq_oe` is never high while output enable is low.
- R7: `req_ready` is low from acceptance until after done. `rsp_done` is a single-cycle pulse that comes `T_RD`+`T_TURN` cycles after a read is accepted, or `T_TURN`+`T_WP`+1 cycles after a write is accepted. `req_ready` is high in the cycle after the pulse.
- R8: Chip select is high in the done cycle, so back-to-back transactions are separated by at least one cycle with every strobe inactive.
- R9: A transaction with lane mask 0 leaves memory unchanged, and a read with mask 0 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane select, bit 1 high lane, bit 0 low lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
A sequencer whose cycle counter is loaded with the wrong length shows at the pins within one transaction. The low time of output enable or write enable, the delay before the bus is driven, or the position of the done pulse then moves by a whole number of cycles. A mis-decoded state shows on the same cycle as overlapping strobes, for example the bus driven while output enable is low, or chip select still low in the done cycle. A wrong lane register or capture point shows on the next read of that word, as a corrupted or non-zero lane in the returned data.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  localparam int DW    = 16;
  localparam int LANES = DW / 8;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RACC   = 3'd1,
    S_RTURN  = 3'd2,
    S_WTURN  = 3'd3,
    S_WPULSE = 3'd4,
    S_WHOLD  = 3'd5,
    S_DONE   = 3'd6
  } st_e;

  // Round a picosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // Keep a byte only when its lane was selected.
  function automatic logic [7:0] lane_pick(input logic en, input logic [7:0] v);
    return en ? v : 8'h00;
  endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int T_RD   = 1,
  parameter int T_WP   = 1,
  parameter int T_TURN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output st_e  state_o,
  output logic cnt_zero_o,
  output logic accept_o
);

  localparam int MAXL = (T_RD > T_WP) ? ((T_RD > T_TURN) ? T_RD : T_TURN)
                                      : ((T_WP > T_TURN) ? T_WP : T_TURN);
  localparam int CW = $clog2(MAXL + 1);

  st_e           st;
  logic [CW-1:0] cnt;
  logic          advance;
  st_e           st_nx;

  function automatic st_e succ(input st_e s, input logic wr);
    case (s)
      S_IDLE:   return wr ? S_WTURN : S_RACC;
      S_RACC:   return S_RTURN;
      S_RTURN:  return S_DONE;
      S_WTURN:  return S_WPULSE;
      S_WPULSE: return S_WHOLD;
      S_WHOLD:  return S_DONE;
      default:  return S_IDLE;
    endcase
  endfunction

  function automatic logic [CW-1:0] load_of(input st_e s);
    case (s)
      S_RACC:           return CW'(T_RD - 1);
      S_RTURN, S_WTURN: return CW'(T_TURN - 1);
      S_WPULSE:         return CW'(T_WP - 1);
      default:          return '0;
    endcase
  endfunction

  assign accept_o   = (st == S_IDLE) && req_valid;
  assign cnt_zero_o = (cnt == '0);
  assign advance    = (st == S_IDLE) ? req_valid : cnt_zero_o;
  assign st_nx      = succ(st, req_write);
  assign state_o    = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (advance) begin
      st  <= st_nx;
      cnt <= load_of(st_nx);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/asram_path.sv
`timescale 1ns/1ps
module asram_path
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               state_i,
  input  logic              cnt_zero_i,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_bmask,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DW-1:0]     mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_in,
  output logic [DW-1:0]     rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DW-1:0]     rdata_q;

  // Named internal events
  logic acc_win, wr_frame, wr_pulse, bus_drive, capture, sel_any;

  assign acc_win   = (state_i == S_RACC);
  assign wr_pulse  = (state_i == S_WPULSE);
  assign wr_frame  = (state_i == S_WTURN) || wr_pulse || (state_i == S_WHOLD);
  assign bus_drive = wr_pulse || (state_i == S_WHOLD);
  assign capture   = acc_win && cnt_zero_i;
  assign sel_any   = acc_win || wr_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_bmask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        rdata_q[g*8 +: 8] <= 8'h00;
      else if (capture)
        rdata_q[g*8 +: 8] <= lane_pick(mask_q[g], mem_dq_in[g*8 +: 8]);
    end
    assign mem_be_n[g] = !(sel_any && mask_q[g]);
  end

  assign mem_addr   = addr_q;
  assign mem_cs_n   = !sel_any;
  assign mem_oe_n   = !acc_win;
  assign mem_we_n   = !wr_pulse;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = bus_drive;
  assign rdata      = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CLK_PS = 20000,
  parameter int T_RD   = ns_to_cyc(15000, CLK_PS),
  parameter int T_WP   = ns_to_cyc(10000, CLK_PS),
  parameter int T_TURN = ns_to_cyc(6000, CLK_PS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_bmask,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  st_e        state;
  logic       cnt_zero;
  logic       accept;
  logic [1:0] be_n;

  asram_seq #(.T_RD(T_RD), .T_WP(T_WP), .T_TURN(T_TURN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .state_o    (state),
    .cnt_zero_o (cnt_zero),
    .accept_o   (accept)
  );

  asram_path #(.ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .cnt_zero_i (cnt_zero),
    .accept_i   (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_bmask  (req_bmask),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_be_n   (be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in),
    .rdata      (rsp_rdata)
  );

  assign mem_ub_n  = be_n[1];
  assign mem_lb_n  = be_n[0];
  assign req_ready = (state == S_IDLE);
  assign rsp_done  = (state == S_DONE);

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int T_RD   = 1,
  parameter int T_WP   = 1,
  parameter int T_TURN = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_done,
  input logic mem_cs_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_ub_n,
  input logic mem_lb_n,
  input logic mem_dq_oe
);

  int oe_hi_cnt, oe_lo_run, we_lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_hi_cnt <= 0;
      oe_lo_run <= 0;
      we_lo_run <= 0;
    end else begin
      oe_hi_cnt <= !mem_oe_n ? 0 : ((oe_hi_cnt < 1000000) ? oe_hi_cnt + 1 : oe_hi_cnt);
      oe_lo_run <= mem_oe_n ? 0 : oe_lo_run + 1;
      we_lo_run <= mem_we_n ? 0 : we_lo_run + 1;
    end
  end

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !rsp_done));

  p_read_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_run == T_RD));

  p_write_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_run == T_WP));

  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= T_TURN));

  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  p_gap_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> mem_cs_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(.T_RD(T_RD), .T_WP(T_WP), .T_TURN(T_TURN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

  localparam int TRD = 3;
  localparam int TWP = 2;
  localparam int TTN = 2;
  localparam int LAT_RD = TRD + TTN;
  localparam int LAT_WR = TTN + TWP + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
  logic [15:0] mem_dq_in;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] model_mem [int];
  logic [15:0] ref_mem   [int];

  always #10 clk = ~clk;

  asram_ctrl #(.T_RD(TRD), .T_WP(TWP), .T_TURN(TTN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: write latched at the end of the write strobe.
  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0) begin
      logic [15:0] w;
      w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      model_mem[int'(mem_addr)] = w;
    end
  end

  // Read drive; disabled lanes carry a junk pattern that must not leak.
  always @(mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_addr) begin
    logic [15:0] v;
    logic        rd;
    v  = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
    rd = !mem_cs_n && !mem_oe_n && mem_we_n;
    mem_dq_in[7:0]  = (rd && !mem_lb_n) ? v[7:0]  : 8'hA5;
    mem_dq_in[15:8] = (rd && !mem_ub_n) ? v[15:8] : 8'h5A;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes_of(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // Runs one transaction; called at a negedge, returns at a negedge.
  task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] d,
                     input logic [1:0] m, output logic [15:0] rd);
    int n = 0, oe_lo = 0, we_lo = 0, drv = 0, first_drv = -1;
    int contend = 0, oe_in_wr = 0, rdy_hi = 0, addr_bad = 0, be_bad = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && n < 100) begin
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) we_lo++;
      if (mem_dq_oe) begin drv++; if (first_drv < 0) first_drv = n; end
      if (mem_dq_oe && !mem_oe_n) contend++;
      if (!mem_we_n && !mem_oe_n) oe_in_wr++;
      if (req_ready) rdy_hi++;
      if (!mem_cs_n && mem_addr != a) addr_bad++;
      if (!mem_cs_n && ((!mem_lb_n && !m[0]) || (!mem_ub_n && !m[1]))) be_bad++;
      @(negedge clk);
      n++;
    end
    chk(n == (wr ? LAT_WR : LAT_RD), "R7", "done latency", n, wr ? LAT_WR : LAT_RD);
    chk(rdy_hi == 0 && !req_ready, "R7", "ready low while busy", rdy_hi, 0);
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R8", "strobes inactive in done cycle",
        {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(contend == 0, "R6", "bus driven with output enable low", contend, 0);
    chk(be_bad == 0, "R3", "unselected lane enable asserted", be_bad, 0);
    if (wr) begin
      chk(we_lo == TWP, "R4", "write pulse length", we_lo, TWP);
      chk(oe_in_wr == 0 && oe_lo == 0, "R4", "output enable low in write", oe_lo, 0);
      chk(first_drv == TTN, "R5", "first drive cycle", first_drv, TTN);
      chk(drv == TWP + 1, "R5", "drive cycles", drv, TWP + 1);
      chk(addr_bad == 0, "R4", "write address", addr_bad, 0);
    end else begin
      chk(oe_lo == TRD, "R2", "read window length", oe_lo, TRD);
      chk(we_lo == 0 && drv == 0, "R2", "write activity in read", we_lo + drv, 0);
      chk(addr_bad == 0, "R2", "read address", addr_bad, 0);
    end
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done && req_ready, "R7", "single done pulse then ready",
        {rsp_done, req_ready}, 2'b01);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
        "R1", "idle standby", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
        6'b111110);
  endtask

  function automatic logic [15:0] addr_of(input int i);
    if (i == 15) return 16'hFFFF;
    return 16'((i * 16'h1357) ^ (i * i * 16'h0101));
  endfunction

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !rsp_done,
        "R1", "strobes during reset",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rsp_done}, 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !mem_dq_oe, "R1", "idle after reset",
        {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = addr_of(i);
      run(1'b1, a, a ^ 16'h3C5A, 2'b11, rd);
      ref_mem[int'(a)] = a ^ 16'h3C5A;
      for (int m = 0; m < 4; m++) begin
        logic [15:0] d, keep;
        d = a ^ 16'((16'h4D2B + m * 16'h1111) & 16'hFFFF);
        run(1'b1, a, d, 2'(m), rd);
        keep = ref_mem[int'(a)];
        ref_mem[int'(a)] = (d & lanes_of(2'(m))) | (keep & ~lanes_of(2'(m)));
        run(1'b0, a, 16'h0000, 2'b11, rd);
        if (m == 0)
          chk(rd == ref_mem[int'(a)], "R9", "masked-off write left word", rd, ref_mem[int'(a)]);
        else
          chk(rd == ref_mem[int'(a)], "R4", "lane write result", rd, ref_mem[int'(a)]);
      end
      for (int m = 0; m < 4; m++) begin
        logic [15:0] e;
        e = ref_mem[int'(a)] & lanes_of(2'(m));
        run(1'b0, a, 16'hFFFF, 2'(m), rd);
        if (m == 0)
          chk(rd == 16'h0000, "R9", "empty-mask read", rd, 16'h0000);
        else
          chk(rd == e, "R3", "lane read data", rd, e);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule